// File: doc/BRIEF.md
# Hybrid Reference-Counted Register Freelist

This block decides which physical registers of a single, conventionally sized register file are free. Two kinds of holder keep a register busy. Ordinary in-flight instructions take a register when they are allocated and give it back in program order at retirement. They are tracked by a circular queue of positions, and a squash rolls the queue tail back. Instructions moved aside into a slice buffer keep registers alive through execution-driven references. Each reference source releases everything it holds when its consumer executes.

Both kinds of holder are kept in one bit matrix. There is one row per physical register and one column per queue position or slice reference source. A register is free exactly when its row is all zero, so one reduction per row serves allocation for both policies. The register data array itself lives outside this block.

Top module: `hybrid_freelist`

## Requirements
- R1: After reset, and after a reset applied mid-operation, every physical register is free and the queue is empty. The next allocation receives register 0 with tag 0.
- R2: `free_vec[r]` is 1 exactly when register r is held by no queue position and no slice source.
- R3: When `alloc_req` is accepted, `alloc_gnt` rises in the same cycle. `alloc_preg` is then the lowest-numbered free register. `alloc_tag` is the queue tail pointer, which holds a wrap bit above the position index and advances by one per grant modulo twice the queue depth. The granted register is no longer free from the next cycle.
- R4: Eligibility for allocation uses the state at the start of the cycle. A register that a release or retirement frees in the same cycle is not granted in that cycle.
- R5: No grant is made while the queue holds its full depth (8 positions by default), and `q_full` reports that state. A retirement in the same cycle does not make room until the next cycle.
- R6: `retire_req` clears the oldest queue position's bit and advances the head. A retirement request while the queue is empty is ignored.
- R7: `hold_req` marks register `hold_preg` as referenced by slice source `hold_src`. `release_req` clears every reference of source `release_src`. If the same source is held and released in one cycle, the new hold survives.
- R8: `squash_req` with tag `squash_to` is accepted only if (tail − `squash_to`) mod 16 does not exceed the queue occupancy. When accepted, every position from `squash_to` up to the tail is cleared in one cycle and the tail becomes `squash_to`. Otherwise the request has no effect.
- R9: In a cycle with `squash_req` high, allocation and retirement requests are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alloc_req | input | 1 | Request one register for an in-order instruction |
| retire_req | input | 1 | In-order retirement of the oldest queue position |
| hold_req | input | 1 | Add a slice reference |
| hold_src | input | 2 | Slice source that takes the reference |
| hold_preg | input | 7 | Register being referenced |
| release_req | input | 1 | Drop all references of one slice source |
| release_src | input | 2 | Slice source being released |
| squash_req | input | 1 | Roll the queue tail back |
| squash_to | input | 4 | Tag of the oldest squashed position |
| alloc_gnt | output | 1 | Allocation accepted this cycle |
| alloc_preg | output | 7 | Granted register |
| alloc_tag | output | 4 | Queue tag of the grant |
| free_vec | output | 128 | One bit per register, 1 when free |
| q_full | output | 1 | Queue holds its full depth |

## Verification
Several properties are checked on every cycle:
- a grant always names a register that was free and has no free register below it;
- the granted register leaves the free set on the next cycle;
- the queue never exceeds its depth and no grant is made when full;
- an accepted squash moves the tail to the requested tag;
- a retirement advances the head by one;
- a squash cycle never allocates.

Other behaviour shows up only in the bench's scenarios, because it depends on what was held earlier: a register outliving its retirement because a slice still references it; the hold-wins rule when a source is held and released together; rejection of an out-of-range squash; a full-queue rollback; and refusal to hand out a register that is being freed in the same cycle.

// File: rtl/hrf_pkg.sv
package hrf_pkg;
  localparam int unsigned HRF_NPREG  = 128;
  localparam int unsigned HRF_QDEPTH = 8;
  localparam int unsigned HRF_NSLICE = 4;

  // forward distance on a ring of the given span
  function automatic int unsigned ring_dist(input int unsigned from_p,
                                            input int unsigned to_p,
                                            input int unsigned span);
    return (to_p + span - from_p) % span;
  endfunction
endpackage

// File: rtl/hrf_ptr_queue.sv
module hrf_ptr_queue
  import hrf_pkg::*;
#(
  parameter int unsigned QDEPTH = HRF_QDEPTH,
  localparam int unsigned IW = $clog2(QDEPTH),
  localparam int unsigned PW = IW + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              alloc_fire,
  input  logic              retire_req,
  input  logic              squash_req,
  input  logic [PW-1:0]     squash_to,
  output logic [PW-1:0]     tail_ptr,
  output logic [IW-1:0]     tail_idx,
  output logic              full,
  output logic              retire_fire,
  output logic              squash_fire,
  output logic [QDEPTH-1:0] clr_mask
);
  localparam int unsigned SPAN = 2 * QDEPTH;

  logic [PW-1:0] head_q, tail_q;
  int unsigned   used_n, sq_len;
  logic          empty;

  function automatic logic [QDEPTH-1:0] span_mask(input int unsigned start,
                                                  input int unsigned len);
    logic [QDEPTH-1:0] m;
    m = '0;
    for (int i = 0; i < QDEPTH; i++) begin
      if (ring_dist(start, i, QDEPTH) < len) m[i] = 1'b1;
    end
    return m;
  endfunction

  always_comb begin
    used_n      = ring_dist(int'(head_q), int'(tail_q), SPAN);
    sq_len      = ring_dist(int'(squash_to), int'(tail_q), SPAN);
    full        = (used_n == QDEPTH);
    empty       = (used_n == 0);
    squash_fire = squash_req && (sq_len <= used_n);
    retire_fire = retire_req && !squash_req && !empty;
    if (squash_fire)
      clr_mask = span_mask(int'(squash_to[IW-1:0]), sq_len);
    else if (retire_fire)
      clr_mask = QDEPTH'(1) << head_q[IW-1:0];
    else
      clr_mask = '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      head_q <= '0;
      tail_q <= '0;
    end else begin
      if (squash_fire)     tail_q <= squash_to;
      else if (alloc_fire) tail_q <= tail_q + PW'(1);
      if (retire_fire)     head_q <= head_q + PW'(1);
    end
  end

  assign tail_ptr = tail_q;
  assign tail_idx = tail_q[IW-1:0];

  a_r5_never_overfull: assert property (@(posedge clk) disable iff (!rst_n)
    used_n <= QDEPTH);
  a_r8_squash_moves_tail: assert property (@(posedge clk) disable iff (!rst_n)
    squash_fire |=> tail_q == $past(squash_to));
  a_r6_retire_advances: assert property (@(posedge clk) disable iff (!rst_n)
    retire_fire |=> head_q == $past(head_q) + PW'(1));
  a_r9_squash_blocks_alloc: assert property (@(posedge clk) disable iff (!rst_n)
    squash_req |-> !alloc_fire);
endmodule

// File: rtl/hrf_refmatrix.sv
module hrf_refmatrix
  import hrf_pkg::*;
#(
  parameter int unsigned NPREG = HRF_NPREG,
  parameter int unsigned NCOL  = HRF_QDEPTH + HRF_NSLICE,
  localparam int unsigned RW = $clog2(NPREG),
  localparam int unsigned CW = $clog2(NCOL)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             set_a_en,
  input  logic [RW-1:0]    set_a_row,
  input  logic [CW-1:0]    set_a_col,
  input  logic             set_b_en,
  input  logic [RW-1:0]    set_b_row,
  input  logic [CW-1:0]    set_b_col,
  input  logic [NCOL-1:0]  clr_mask,
  output logic [NPREG-1:0] free_vec
);
  function automatic logic [NCOL-1:0] col_bit(input logic [CW-1:0] c);
    return NCOL'(1) << c;
  endfunction

  for (genvar r = 0; r < NPREG; r++) begin : g_row
    logic [NCOL-1:0] row_q, row_set;
    always_comb begin
      row_set = '0;
      if (set_a_en && set_a_row == RW'(r)) row_set = row_set | col_bit(set_a_col);
      if (set_b_en && set_b_row == RW'(r)) row_set = row_set | col_bit(set_b_col);
    end
    always_ff @(posedge clk) begin
      if (!rst_n) row_q <= '0;
      else        row_q <= (row_q & ~clr_mask) | row_set;
    end
    assign free_vec[r] = ~|row_q;
  end

  a_r2_set_holds_row: assert property (@(posedge clk) disable iff (!rst_n)
    set_b_en |=> !free_vec[$past(set_b_row)]);
endmodule

// File: rtl/hrf_pick.sv
module hrf_pick
  import hrf_pkg::*;
#(
  parameter int unsigned N = HRF_NPREG,
  localparam int unsigned IW = $clog2(N)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] cand,
  output logic         found,
  output logic [IW-1:0] idx
);
  function automatic logic [IW-1:0] lowest_one(input logic [N-1:0] v);
    logic [IW-1:0] k;
    k = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (v[i]) k = IW'(i);
    end
    return k;
  endfunction

  assign found = |cand;
  assign idx   = lowest_one(cand);

  a_r3_lowest_pick: assert property (@(posedge clk) disable iff (!rst_n)
    found |-> (cand[idx] && ((cand & ((N'(1) << idx) - N'(1))) == '0)));
endmodule

// File: rtl/hybrid_freelist.sv
module hybrid_freelist
  import hrf_pkg::*;
#(
  parameter int unsigned NPREG  = HRF_NPREG,
  parameter int unsigned QDEPTH = HRF_QDEPTH,
  parameter int unsigned NSLICE = HRF_NSLICE,
  localparam int unsigned RW   = $clog2(NPREG),
  localparam int unsigned IW   = $clog2(QDEPTH),
  localparam int unsigned PW   = IW + 1,
  localparam int unsigned SW   = $clog2(NSLICE),
  localparam int unsigned NCOL = QDEPTH + NSLICE,
  localparam int unsigned CW   = $clog2(NCOL)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             alloc_req,
  input  logic             retire_req,
  input  logic             hold_req,
  input  logic [SW-1:0]    hold_src,
  input  logic [RW-1:0]    hold_preg,
  input  logic             release_req,
  input  logic [SW-1:0]    release_src,
  input  logic             squash_req,
  input  logic [PW-1:0]    squash_to,
  output logic             alloc_gnt,
  output logic [RW-1:0]    alloc_preg,
  output logic [PW-1:0]    alloc_tag,
  output logic [NPREG-1:0] free_vec,
  output logic             q_full
);
  logic              pick_found;
  logic [RW-1:0]     pick_idx;
  logic              alloc_fire, retire_fire, squash_fire;
  logic [PW-1:0]     tail_ptr;
  logic [IW-1:0]     tail_idx;
  logic [QDEPTH-1:0] q_clr;
  logic [NSLICE-1:0] s_clr;
  logic [NCOL-1:0]   clr_all;
  logic [CW-1:0]     hold_col;

  assign alloc_fire = alloc_req && !squash_req && !q_full && pick_found;
  assign s_clr      = release_req ? (NSLICE'(1) << release_src) : '0;
  assign clr_all    = {s_clr, q_clr};
  assign hold_col   = CW'(QDEPTH) + CW'(hold_src);

  hrf_ptr_queue #(.QDEPTH(QDEPTH)) u_queue (
    .clk(clk), .rst_n(rst_n),
    .alloc_fire(alloc_fire), .retire_req(retire_req),
    .squash_req(squash_req), .squash_to(squash_to),
    .tail_ptr(tail_ptr), .tail_idx(tail_idx), .full(q_full),
    .retire_fire(retire_fire), .squash_fire(squash_fire),
    .clr_mask(q_clr)
  );

  hrf_refmatrix #(.NPREG(NPREG), .NCOL(NCOL)) u_matrix (
    .clk(clk), .rst_n(rst_n),
    .set_a_en(alloc_fire), .set_a_row(pick_idx), .set_a_col(CW'(tail_idx)),
    .set_b_en(hold_req), .set_b_row(hold_preg), .set_b_col(hold_col),
    .clr_mask(clr_all), .free_vec(free_vec)
  );

  hrf_pick #(.N(NPREG)) u_pick (
    .clk(clk), .rst_n(rst_n),
    .cand(free_vec), .found(pick_found), .idx(pick_idx)
  );

  assign alloc_gnt  = alloc_fire;
  assign alloc_preg = pick_idx;
  assign alloc_tag  = tail_ptr;

  a_r4_grant_was_free: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_gnt |-> free_vec[alloc_preg]);
  a_r3_grant_taken: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_gnt |=> !free_vec[$past(alloc_preg)]);
  a_r5_no_grant_full: assert property (@(posedge clk) disable iff (!rst_n)
    q_full |-> !alloc_gnt);
  a_r8_squash_no_retire: assert property (@(posedge clk) disable iff (!rst_n)
    squash_fire |-> !retire_fire);
endmodule

// File: tb/tb_hybrid_freelist.sv
`timescale 1ns/100ps
module tb_hybrid_freelist;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         alloc_req = 0, retire_req = 0, hold_req = 0, release_req = 0, squash_req = 0;
  logic [1:0]   hold_src = 0, release_src = 0;
  logic [6:0]   hold_preg = 0;
  logic [3:0]   squash_to = 0;
  logic         alloc_gnt, q_full;
  logic [6:0]   alloc_preg;
  logic [3:0]   alloc_tag;
  logic [127:0] free_vec;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  hybrid_freelist dut (
    .clk(clk), .rst_n(rst_n), .alloc_req(alloc_req), .retire_req(retire_req),
    .hold_req(hold_req), .hold_src(hold_src), .hold_preg(hold_preg),
    .release_req(release_req), .release_src(release_src),
    .squash_req(squash_req), .squash_to(squash_to),
    .alloc_gnt(alloc_gnt), .alloc_preg(alloc_preg), .alloc_tag(alloc_tag),
    .free_vec(free_vec), .q_full(q_full)
  );

  typedef struct packed {
    logic       al; logic rt; logic hd; logic [1:0] hs; logic [6:0] hp;
    logic       rl; logic [1:0] rs; logic sq; logic [3:0] st;
    logic       eg; logic [6:0] ep; logic [3:0] et; logic [7:0] ef;
  } vec_t;

  //                al rt hd hs hp rl rs sq st  eg ep et  ef
  localparam vec_t TBL [31] = '{
    '{1,0,0,0,0, 0,0,0,0, 1,0,0, 127},   // R3
    '{1,0,0,0,0, 0,0,0,0, 1,1,1, 126},   // R3
    '{1,0,0,0,0, 0,0,0,0, 1,2,2, 125},   // R3
    '{0,0,1,0,0, 0,0,0,0, 0,0,0, 125},   // R7 hold preg0 on src0
    '{0,1,0,0,0, 0,0,0,0, 0,0,0, 125},   // R7 retire tag0, still held
    '{0,1,0,0,0, 0,0,0,0, 0,0,0, 126},   // R6 retire tag1 frees preg1
    '{1,0,0,0,0, 1,0,0,0, 1,1,3, 126},   // R4 preg0 freed now, not granted
    '{1,0,0,0,0, 0,0,0,0, 1,0,4, 125},
    '{1,0,0,0,0, 0,0,0,0, 1,3,5, 124},
    '{1,0,0,0,0, 0,0,1,4, 0,0,0, 126},   // R8 R9 squash tags 4,5
    '{1,0,0,0,0, 0,0,0,0, 1,0,4, 125},   // R8 tail back at 4
    '{0,0,1,1,2, 0,0,0,0, 0,0,0, 125},   // R7 hold preg2 on src1
    '{0,1,0,0,0, 0,0,0,0, 0,0,0, 125},   // R7 retire tag2, held
    '{0,1,0,0,0, 1,1,0,0, 0,0,0, 127},   // R6 R7
    '{1,0,0,0,0, 0,0,0,0, 1,1,5, 126},
    '{1,0,0,0,0, 0,0,0,0, 1,2,6, 125},
    '{1,0,0,0,0, 0,0,0,0, 1,3,7, 124},
    '{1,0,0,0,0, 0,0,0,0, 1,4,8, 123},
    '{1,0,0,0,0, 0,0,0,0, 1,5,9, 122},
    '{1,0,0,0,0, 0,0,0,0, 1,6,10,121},
    '{1,0,0,0,0, 0,0,0,0, 1,7,11,120},
    '{1,0,0,0,0, 0,0,0,0, 0,0,0, 120},   // R5 full
    '{0,0,0,0,0, 0,0,1,3, 0,0,0, 120},   // R8 out of range, ignored
    '{1,1,0,0,0, 0,0,0,0, 0,0,0, 121},   // R5 retire does not open slot now
    '{1,0,0,0,0, 0,0,0,0, 1,0,12,120},   // R3 tag wrap bit
    '{0,0,0,0,0, 0,0,1,5, 0,0,0, 128},   // R8 squash full queue
    '{0,1,0,0,0, 0,0,0,0, 0,0,0, 128},   // R6 retire empty ignored
    '{1,0,0,0,0, 0,0,0,0, 1,0,5, 127},
    '{0,0,1,2,0, 1,2,0,0, 0,0,0, 127},   // R7 hold wins
    '{0,1,0,0,0, 0,0,0,0, 0,0,0, 127},   // R7 still held after retire
    '{0,0,0,0,0, 1,2,0,0, 0,0,0, 128}    // R2 released
  };

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic idle_inputs();
    alloc_req = 0; retire_req = 0; hold_req = 0; release_req = 0; squash_req = 0;
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1", "free count", $countones(free_vec), 128);
    chk("R1", "q_full", int'(q_full), 0);
    chk("R1", "grant idle", int'(alloc_gnt), 0);

    for (int i = 0; i < 31; i++) begin
      alloc_req = TBL[i].al; retire_req = TBL[i].rt;
      hold_req = TBL[i].hd; hold_src = TBL[i].hs; hold_preg = TBL[i].hp;
      release_req = TBL[i].rl; release_src = TBL[i].rs;
      squash_req = TBL[i].sq; squash_to = TBL[i].st;
      #1;
      chk($sformatf("R3 row%0d", i), "grant", int'(alloc_gnt), int'(TBL[i].eg));
      if (TBL[i].eg) begin
        chk($sformatf("R3 row%0d", i), "preg", int'(alloc_preg), int'(TBL[i].ep));
        chk($sformatf("R3 row%0d", i), "tag", int'(alloc_tag), int'(TBL[i].et));
      end
      @(negedge clk);
      idle_inputs();
      chk($sformatf("R2 row%0d", i), "free count", $countones(free_vec), int'(TBL[i].ef));
    end

    // R5: fill the empty queue, q_full must rise after 8 grants
    for (int k = 0; k < 8; k++) begin
      alloc_req = 1;
      #1;
      chk("R5", "fill grant", int'(alloc_gnt), 1);
      chk("R5", "fill preg", int'(alloc_preg), k);
      @(negedge clk);
    end
    idle_inputs();
    chk("R5", "q_full", int'(q_full), 1);
    chk("R2", "free after fill", $countones(free_vec), 120);

    // R1: reset mid-operation
    rst_n = 0;
    @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1", "free after reset", $countones(free_vec), 128);
    chk("R1", "q_full after reset", int'(q_full), 0);
    alloc_req = 1;
    #1;
    chk("R1", "first preg", int'(alloc_preg), 0);
    chk("R1", "first tag", int'(alloc_tag), 0);
    @(negedge clk);
    idle_inputs();

    done = 1;
    summary();
    $finish;
  end
endmodule